// File: doc/BRIEF.md
# Three-Bank Interrupt Cause Controller

The block collects single-cycle event pulses from a datapath into three 32-bit cause banks: receive, transmit and miscellaneous. Each bank keeps its own per-bit mask. The mask is changed through separate set and clear write ports and can be read back from its own read-only register. Each bank also has a clear-mode register, changeable at run time, that chooses how pending bits are acknowledged. In write-one-to-clear mode, writing to the cause register clears the bits written as one. In clear-on-read mode, reading the cause register returns it and empties it.

A summary register holds one bit per bank. A bit is set while its bank has any pending bit that is not masked, and reading the summary clears it. A summary mask gates the summary bits, and what remains drives a single level-sensitive interrupt line. Software reads the summary to find which banks need service, then reads and acknowledges those banks.

The register port is a simple single-cycle interface. A write is applied at the clock edge. A read captures the addressed value into `reg_rdata` at the clock edge where `reg_rd` is high.

Top module: `irq_cause_ctrl`

## Requirements
- R1: Word address map: bit 4 and bit 3 select a page (0 receive, 1 transmit, 2 miscellaneous, 3 summary), and bits 2 to 0 select the register. In a bank page: 0 is cause, 1 is mask-set, 2 is mask-clear, 3 is mask value, 4 is clear mode. In the summary page: 0 is summary cause (bank b in bit b) and 1 is summary mask. Unlisted addresses and the two mask ports read as zero. After reset every cause is zero, every bank mask reads 0xFFFFFFFF, every clear mode reads 0, the summary reads 0, the summary mask reads 0x7, and `irq_out` is low.
- R2: An event pulse on a bit sets that cause bit. Set bits stay set until cleared, and later pulses OR into the bank.
- R3: In write-one-to-clear mode, writing the cause register clears exactly the bits written as one. Reading does not clear.
- R4: Writing 0xFFFFFFFF to a clear-mode register selects clear-on-read, and the mode then reads as 0xFFFFFFFF. Any other written value selects write-one-to-clear, and the mode reads as 0. In clear-on-read mode, a cause read returns the bits and clears them, and writes to the cause register have no effect.
- R5: An event that arrives in the same cycle as a clear (by write or by read) leaves its bit set.
- R6: A mask-set write masks each bit written as one and leaves the other mask bits as they were.
- R7: A mask-clear write unmasks each bit written as one and leaves the other mask bits as they were. The result is visible in the mask value register.
- R8: Summary bit b is set whenever bank b has a pending bit that is not masked. A masked bit still latches its event and feeds the summary once unmasked.
- R9: A summary read returns the current bits and clears them. A bank that is still active sets its bit again.
- R10: The summary mask gates each summary bit from the interrupt. Writing 0x7 blocks every bank.
- R11: `irq_out` is high exactly while some summary bit is set and not masked in the summary mask, two clock edges after the cause change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx | input | 32 | Receive event pulses, one per cause bit |
| ev_tx | input | 32 | Transmit event pulses |
| ev_misc | input | 32 | Miscellaneous event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Level interrupt line |

## Verification
Directed sequences run each bank through both clear modes. They tell a read that clears apart from one that only returns the bits, and a partial acknowledge apart from a full one. Collisions of an event with a clear written in the same cycle, and of an event with a clearing read, separate set-wins from clear-wins. Masking is tried on pending bits to show that events are still latched and appear only after unmasking. Summary reads are tried with the bank still active and with the bank already emptied, which shows that the summary is sticky. A seeded random mix of events, mask writes, mode switches, acknowledges and reads on all pages is then compared against a bench model.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int NUM_BANKS = 3;
  localparam int PAGE_W    = 2;
  localparam int OFS_W     = 3;
  localparam int ADDR_W    = PAGE_W + OFS_W;

  typedef enum logic [OFS_W-1:0] {
    OFS_CAUSE = 3'd0,
    OFS_MSET  = 3'd1,
    OFS_MCLR  = 3'd2,
    OFS_MVAL  = 3'd3,
    OFS_MODE  = 3'd4
  } bank_ofs_e;

  localparam logic [PAGE_W-1:0] SUM_PAGE      = 2'd3;
  localparam logic [OFS_W-1:0]  OFS_SUM_CAUSE = 3'd0;
  localparam logic [OFS_W-1:0]  OFS_SUM_MASK  = 3'd1;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         wr_cause,
  input  logic         rd_cause,
  input  logic         wr_mset,
  input  logic         wr_mclr,
  input  logic         wr_mode,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause,
  output logic [W-1:0] mask,
  output logic         cor_mode,
  output logic         active
);
  logic [W-1:0] clr;

  // acknowledge path depends on the run-time mode
  always_comb begin
    if (cor_mode) clr = rd_cause ? '1 : '0;
    else          clr = wr_cause ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause    <= '0;
      mask     <= '1;
      cor_mode <= 1'b0;
    end else begin
      cause <= (cause & ~clr) | ev;   // set wins over clear
      if (wr_mset)      mask <= mask | wdata;
      else if (wr_mclr) mask <= mask & ~wdata;
      if (wr_mode) cor_mode <= &wdata;
    end
  end

  assign active = |(cause & ~mask);
endmodule

// File: rtl/irq_cause_summary.sv
module irq_cause_summary #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] active,
  input  logic         rd_sum,
  input  logic         wr_smask,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] sum,
  output logic [N-1:0] smask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      smask <= '1;
      irq   <= 1'b0;
    end else begin
      sum <= (rd_sum ? '0 : sum) | active;
      if (wr_smask) smask <= wdata;
      irq <= |(sum & ~smask);
    end
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ev_rx,
  input  logic [DATA_W-1:0] ev_tx,
  input  logic [DATA_W-1:0] ev_misc,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  assign page = reg_addr[ADDR_W-1:OFS_W];
  assign ofs  = reg_addr[OFS_W-1:0];

  logic [NUM_BANKS-1:0][DATA_W-1:0] ev_a;
  logic [NUM_BANKS-1:0][DATA_W-1:0] cause_a;
  logic [NUM_BANKS-1:0][DATA_W-1:0] mask_a;
  logic [NUM_BANKS-1:0]             cor_a;
  logic [NUM_BANKS-1:0]             active_a;
  logic [NUM_BANKS-1:0]             sum;
  logic [NUM_BANKS-1:0]             smask;

  assign ev_a[0] = ev_rx;
  assign ev_a[1] = ev_tx;
  assign ev_a[2] = ev_misc;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (page == PAGE_W'(b));
    irq_cause_bank #(.W(DATA_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .ev       (ev_a[b]),
      .wr_cause (reg_wr && hit && ofs == OFS_CAUSE),
      .rd_cause (reg_rd && hit && ofs == OFS_CAUSE),
      .wr_mset  (reg_wr && hit && ofs == OFS_MSET),
      .wr_mclr  (reg_wr && hit && ofs == OFS_MCLR),
      .wr_mode  (reg_wr && hit && ofs == OFS_MODE),
      .wdata    (reg_wdata),
      .cause    (cause_a[b]),
      .mask     (mask_a[b]),
      .cor_mode (cor_a[b]),
      .active   (active_a[b])
    );
  end

  irq_cause_summary #(.N(NUM_BANKS)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .active   (active_a),
    .rd_sum   (reg_rd && page == SUM_PAGE && ofs == OFS_SUM_CAUSE),
    .wr_smask (reg_wr && page == SUM_PAGE && ofs == OFS_SUM_MASK),
    .wdata    (reg_wdata[NUM_BANKS-1:0]),
    .sum      (sum),
    .smask    (smask),
    .irq      (irq_out)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (page == SUM_PAGE) begin
      if (ofs == OFS_SUM_CAUSE)     rd_mux = {{(DATA_W-NUM_BANKS){1'b0}}, sum};
      else if (ofs == OFS_SUM_MASK) rd_mux = {{(DATA_W-NUM_BANKS){1'b0}}, smask};
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (page == PAGE_W'(b)) begin
          case (ofs)
            OFS_CAUSE: rd_mux = cause_a[b];
            OFS_MVAL:  rd_mux = mask_a[b];
            OFS_MODE:  rd_mux = {DATA_W{cor_a[b]}};
            default:   rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int W = 32,
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [4:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] ev_rx,
  input logic [W-1:0] cause0,
  input logic [W-1:0] mask0,
  input logic         cor0,
  input logic [N-1:0] sum,
  input logic [N-1:0] smask,
  input logic         irq_out
);
  // R2 also: a pulse always lands in the cause register
  assert_event_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_rx != '0) |=> ((cause0 & $past(ev_rx)) == $past(ev_rx)));

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 5'h01) |=> (mask0 == ($past(mask0) | $past(reg_wdata))));

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 5'h02) |=> (mask0 == ($past(mask0) & ~$past(reg_wdata))));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (cor0 && reg_rd && reg_addr == 5'h00 && ev_rx == '0) |=> (cause0 == '0));

  assert_all_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (smask == '1) |=> !irq_out);

  assert_irq_level_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(sum & ~smask))));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.W(DATA_W), .N(irq_cause_pkg::NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ev_rx     (ev_rx),
  .cause0    (cause_a[0]),
  .mask0     (mask_a[0]),
  .cor0      (cor_a[0]),
  .sum       (sum),
  .smask     (smask),
  .irq_out   (irq_out)
);

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ev_rx = '0, ev_tx = '0, ev_misc = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_cause [3];
  logic [31:0] m_mask  [3];
  logic        m_cor   [3];
  logic [2:0]  m_sum;
  logic [2:0]  m_smask;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_ctrl uut (
    .clk(clk), .rst(rst), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_misc(ev_misc),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [2:0] m_active();
    logic [2:0] a;
    for (int b = 0; b < 3; b++) a[b] = |(m_cause[b] & ~m_mask[b]);
    return a;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [1:0] pg = a[4:3];
    logic [2:0] of = a[2:0];
    if (pg == 2'd3) begin
      if (of == 3'd0) return {29'd0, m_sum};
      if (of == 3'd1) return {29'd0, m_smask};
      return '0;
    end
    case (of)
      3'd0: return m_cause[pg];
      3'd3: return m_mask[pg];
      3'd4: return m_cor[pg] ? 32'hFFFF_FFFF : 32'h0;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus access with optional event pulses, model update and checks
  task automatic op(input string req, input bit wr, input bit rd, input logic [4:0] a,
                    input logic [31:0] wd, input logic [31:0] e0, input logic [31:0] e1,
                    input logic [31:0] e2);
    logic [31:0] exp_rd;
    logic [31:0] got;
    logic [31:0] ev [3];
    logic [1:0]  pg = a[4:3];
    logic [2:0]  of = a[2:0];
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    exp_rd = m_read(a);
    // model: summary captures current activity, read clears first
    if (rd && pg == 2'd3 && of == 3'd0) m_sum = '0;
    m_sum |= m_active();
    for (int b = 0; b < 3; b++) begin
      logic [31:0] clr = '0;
      if (pg == 2'(b) && of == 3'd0) begin
        if (m_cor[b] && rd) clr = '1;
        else if (!m_cor[b] && wr) clr = wd;
      end
      m_cause[b] = (m_cause[b] & ~clr) | ev[b];
      if (wr && pg == 2'(b) && of == 3'd1) m_mask[b] = m_mask[b] | wd;
      if (wr && pg == 2'(b) && of == 3'd2) m_mask[b] = m_mask[b] & ~wd;
      if (wr && pg == 2'(b) && of == 3'd4) m_cor[b] = &wd;
    end
    if (wr && pg == 2'd3 && of == 3'd1) m_smask = wd[2:0];
    m_sum |= m_active();

    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    ev_rx = e0; ev_tx = e1; ev_misc = e2;
    @(posedge clk);
    #1 got = reg_rdata;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; ev_rx = '0; ev_tx = '0; ev_misc = '0;
    repeat (3) @(negedge clk);
    if (rd) check(req, got, exp_rd);
    check({req, " R11 irq"}, {31'd0, irq_out}, {31'd0, |(m_sum & ~m_smask)});
  endtask

  task automatic rd_op(input string req, input logic [4:0] a);
    op(req, 0, 1, a, '0, '0, '0, '0);
  endtask
  task automatic wr_op(input string req, input logic [4:0] a, input logic [31:0] d);
    op(req, 1, 0, a, d, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B_3C4D));
    for (int b = 0; b < 3; b++) begin
      m_cause[b] = '0; m_mask[b] = '1; m_cor[b] = 1'b0;
    end
    m_sum = '0; m_smask = 3'h7;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset values on every page
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    for (int b = 0; b < 3; b++) begin
      rd_op("R1 cause", 5'(b*8 + 0));
      rd_op("R1 mask", 5'(b*8 + 3));
      rd_op("R1 mode", 5'(b*8 + 4));
      rd_op("R1 mset reads 0", 5'(b*8 + 1));
    end
    rd_op("R1 sum", 5'h18);
    rd_op("R1 smask", 5'h19);

    // R2 accumulation
    op("R2 pulse", 0, 0, 5'h00, '0, 32'h5, '0, '0);
    op("R2 pulse", 0, 0, 5'h00, '0, 32'h100, '0, '0);
    rd_op("R2 accumulate", 5'h00);
    // R3 partial acknowledge, read does not clear
    wr_op("R3 w1c", 5'h00, 32'h4);
    rd_op("R3 partial", 5'h00);
    rd_op("R3 no clear on read", 5'h00);
    // R8 masked bits latched, summary unmasked but bank masked
    wr_op("R10 smask open", 5'h19, 32'h0);
    wr_op("R7 unmask bit0", 5'h02, 32'h1);
    rd_op("R7 mask value", 5'h03);
    // R9 sticky summary
    rd_op("R9 sum active", 5'h18);
    rd_op("R9 sum reset", 5'h18);
    wr_op("R3 full ack", 5'h00, 32'h105);
    rd_op("R9 sum sticky", 5'h18);
    rd_op("R9 sum cleared", 5'h18);
    // R10 gating
    op("R8 pulse", 0, 0, 5'h00, '0, 32'h1, '0, '0);
    wr_op("R10 block rx", 5'h19, 32'h1);
    wr_op("R10 block all", 5'h19, 32'h7);
    wr_op("R10 reopen", 5'h19, 32'h0);
    wr_op("R3 ack", 5'h00, 32'h1);
    rd_op("R9 drain", 5'h18);
    // R4 clear-on-read on transmit
    wr_op("R4 mode cor", 5'h0C, 32'hFFFF_FFFF);
    rd_op("R4 mode readback", 5'h0C);
    op("R4 pulse", 0, 0, 5'h08, '0, '0, 32'hF0, '0);
    wr_op("R4 write ignored", 5'h08, 32'hF0);
    rd_op("R4 read returns", 5'h08);
    rd_op("R4 read cleared", 5'h08);
    // R5 event during clearing read
    op("R5 pulse", 0, 0, 5'h08, '0, '0, 32'h3, '0);
    op("R5 cor collide", 0, 1, 5'h08, '0, '0, 32'h2, '0);
    rd_op("R5 kept after read", 5'h08);
    wr_op("R4 mode back", 5'h0C, 32'h12);
    rd_op("R4 mode w1c", 5'h0C);
    // R5 event during write clear on misc
    op("R5 pulse", 0, 0, 5'h10, '0, '0, '0, 32'h8);
    op("R5 w1c collide", 1, 0, 5'h10, 32'h8, '0, '0, 32'h8);
    rd_op("R5 kept after write", 5'h10);
    // R6 / R7 partial mask changes
    wr_op("R7 unmask misc", 5'h12, 32'hFFFF_0000);
    wr_op("R6 mask set", 5'h11, 32'h0F00_0000);
    rd_op("R6 mask value", 5'h13);
    wr_op("R7 unmask misc bit3", 5'h12, 32'h8);
    rd_op("R8 sum misc", 5'h18);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned k = $urandom_range(0, 9);
      logic [1:0]  pg = 2'($urandom_range(0, 2));
      logic [31:0] d  = $urandom;
      logic [31:0] e  = $urandom & $urandom & $urandom;
      case (k)
        0, 1: op("R2 rand ev", 0, 0, 5'h00, '0, e, $urandom & $urandom & $urandom, e ^ 32'h0F);
        2:    wr_op("R3 rand ack", {pg, 3'd0}, d);
        3:    rd_op("R4 rand cause", {pg, 3'd0});
        4:    wr_op("R6 rand mset", {pg, 3'd1}, d & $urandom);
        5:    wr_op("R7 rand mclr", {pg, 3'd2}, d);
        6:    rd_op("R7 rand mval", {pg, 3'd3});
        7:    wr_op("R4 rand mode", {pg, 3'd4}, (d[0]) ? 32'hFFFF_FFFF : d);
        8:    rd_op("R9 rand sum", 5'h18);
        default: wr_op("R10 rand smask", 5'h19, {29'd0, d[2:0]});
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule